// File: doc/BRIEF.md
# Mailbox interrupt CSR block

This block holds the interrupt control registers for a mailbox that carries events in two directions: toward a device and toward a host. Each direction has a generate register, a mask register, a clear register, a status register and a mask-status register, all reached through a single-cycle 32-bit register port. A write to a generate register records an event, and a write to a clear register acknowledges it. The mask register decides which sources are allowed to raise an event.

Each bit of a direction's clear register also serves as an "armed" flag. A source that fires is disarmed, and it stays blocked until software writes a 1 to that bit of the clear register. The mask and mask-status registers always hold bitwise inverse copies of each other. Only the device direction drives an interrupt line. That line appears on a doorbell vector at an index set by the mailbox instance number. The host direction is observed by polling its status registers.

Top module: `mbx_irq_csr`

## Requirements
- R1: Addresses are byte addresses. Bit 5 selects the direction (0 = device, 1 = host). The low five bits select the register: 0x00 generate, 0x04 mask, 0x08 clear, 0x0C status, 0x10 mask-status. Any address with bits 7:6 or bits 1:0 nonzero, or with any other low offset, is unmapped. Read data is combinational from the address.
- R2: After reset, in both directions, generate, status and mask read 0 and mask-status reads all ones. Every source is armed, and the device interrupt is low.
- R3: Writing V to a generate register loads V into both that direction's generate register and its status register.
- R4: On a generate write, the bits of (V AND mask-status AND armed) are disarmed. Every other armed bit keeps its state.
- R5: A device-direction generate write with (V AND mask-status AND armed) nonzero sets the device interrupt on the next clock. A generate write with that term zero leaves the interrupt unchanged.
- R6: Writing V to a clear register removes the 1 bits of V from that direction's generate and status registers and re-arms those bits. The value V is not stored.
- R7: Any write to the device clear register drives the device interrupt low on the next clock.
- R8: Writing V to a mask register stores V (1 = masked) and loads NOT V into mask-status (1 = enabled).
- R9: Both clear registers always read 0.
- R10: Writes to the status and mask-status registers change nothing.
- R11: Unmapped addresses read 0, and writes to them change nothing.
- R12: Host-direction writes never change the device interrupt.
- R13: The doorbell vector carries the device interrupt at bit DB_COUNT-1-INST_ID, and all its other bits are 0.
- R14: A second generate of a pending, unserviced source does not raise the interrupt again. After a clear write to that source, the same generate fires again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 8 | Byte address for reads and writes |
| we | input | 1 | Write strobe, one write per cycle |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for addr |
| dev_irq | output | 1 | Level interrupt toward the device |
| doorbell | output | DB_COUNT | Doorbell vector carrying dev_irq at its instance index |

## Verification
The hardest state to reach from the ports is a source that is disarmed but no longer visible. This happens when a clear write to other bits has already dropped the interrupt, so the armed flag can be seen only through what a later generate fails to do. A directed sequence sets up this case. It fires one bit, clears a different bit, regenerates the first bit and expects no interrupt, then clears the first bit and expects it to fire again. Random traffic, biased toward a few low bits and mixed with mask writes, keeps re-creating partially armed states across both directions.

// File: rtl/mbx_irq_pkg.sv
package mbx_irq_pkg;

    parameter int unsigned DATA_W  = 32;
    parameter int unsigned ADDR_W  = 8;
    parameter int unsigned DIR_BIT = 5;
    parameter int unsigned N_DIR   = 2;

    localparam logic [DIR_BIT-1:0] OFF_GEN   = 5'h00;
    localparam logic [DIR_BIT-1:0] OFF_MASK  = 5'h04;
    localparam logic [DIR_BIT-1:0] OFF_CLR   = 5'h08;
    localparam logic [DIR_BIT-1:0] OFF_STAT  = 5'h0C;
    localparam logic [DIR_BIT-1:0] OFF_MSTAT = 5'h10;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_GEN,
        SEL_MASK,
        SEL_CLR,
        SEL_STAT,
        SEL_MSTAT
    } reg_sel_e;

    typedef struct packed {
        logic     dir;
        reg_sel_e sel;
    } decode_t;

    // Software-visible state of one direction (armed flags stay internal)
    typedef struct packed {
        logic [DATA_W-1:0] gen;
        logic [DATA_W-1:0] mask;
        logic [DATA_W-1:0] stat;
        logic [DATA_W-1:0] mstat;
    } dir_view_t;

    function automatic decode_t decode_addr(input logic [ADDR_W-1:0] a);
        decode_t r;
        r.dir = a[DIR_BIT];
        r.sel = SEL_NONE;
        if (a[ADDR_W-1:DIR_BIT+1] == '0 && a[1:0] == 2'b00) begin
            case (a[DIR_BIT-1:0])
                OFF_GEN:   r.sel = SEL_GEN;
                OFF_MASK:  r.sel = SEL_MASK;
                OFF_CLR:   r.sel = SEL_CLR;
                OFF_STAT:  r.sel = SEL_STAT;
                OFF_MSTAT: r.sel = SEL_MSTAT;
                default:   r.sel = SEL_NONE;
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/mbx_addr_decode.sv
module mbx_addr_decode
    import mbx_irq_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    output decode_t           dec,
    output logic [N_DIR-1:0]  wr_en
);

    always_comb dec = decode_addr(addr);

    for (genvar d = 0; d < N_DIR; d++) begin : g_wr
        assign wr_en[d] = we && (dec.dir == 1'(d)) && (dec.sel != SEL_NONE);
    end

endmodule

// File: rtl/mbx_dir_regs.sv
module mbx_dir_regs
    import mbx_irq_pkg::*;
#(
    parameter bit HAS_IRQ = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  reg_sel_e          sel,
    input  logic [DATA_W-1:0] wdata,
    output dir_view_t         view,
    output logic              irq
);

    logic [DATA_W-1:0] gen_q, mask_q, armed_q, stat_q, mstat_q;
    logic [DATA_W-1:0] fire;
    logic              gen_wr, clr_wr;

    // Sources that are written, enabled and still armed
    assign fire   = wdata & mstat_q & armed_q;
    assign gen_wr = wr_en && (sel == SEL_GEN);
    assign clr_wr = wr_en && (sel == SEL_CLR);

    always_ff @(posedge clk) begin
        if (rst) begin
            gen_q   <= '0;
            mask_q  <= '0;
            armed_q <= '1;
            stat_q  <= '0;
            mstat_q <= '1;
        end else if (wr_en) begin
            case (sel)
                SEL_GEN: begin
                    gen_q   <= wdata;
                    stat_q  <= wdata;
                    armed_q <= armed_q & ~fire;
                end
                SEL_CLR: begin
                    gen_q   <= gen_q & ~wdata;
                    stat_q  <= stat_q & ~wdata;
                    armed_q <= armed_q | wdata;
                end
                SEL_MASK: begin
                    mask_q  <= wdata;
                    mstat_q <= ~wdata;
                end
                default: ;
            endcase
        end
    end

    if (HAS_IRQ) begin : g_irq
        logic irq_q;
        always_ff @(posedge clk) begin
            if (rst)
                irq_q <= 1'b0;
            else if (clr_wr)
                irq_q <= 1'b0;
            else if (gen_wr && (fire != '0))
                irq_q <= 1'b1;
        end
        assign irq = irq_q;
    end else begin : g_no_irq
        assign irq = 1'b0;
    end

    assign view.gen   = gen_q;
    assign view.mask  = mask_q;
    assign view.stat  = stat_q;
    assign view.mstat = mstat_q;

endmodule

// File: rtl/mbx_read_mux.sv
module mbx_read_mux
    import mbx_irq_pkg::*;
(
    input  decode_t                dec,
    input  dir_view_t [N_DIR-1:0]  views,
    output logic [DATA_W-1:0]      rdata
);

    dir_view_t v;

    always_comb begin
        v = views[dec.dir];
        case (dec.sel)
            SEL_GEN:   rdata = v.gen;
            SEL_MASK:  rdata = v.mask;
            SEL_STAT:  rdata = v.stat;
            SEL_MSTAT: rdata = v.mstat;
            default:   rdata = '0;   // clear is write-only, unmapped reads 0
        endcase
    end

endmodule

// File: rtl/mbx_irq_csr.sv
module mbx_irq_csr
    import mbx_irq_pkg::*;
#(
    parameter int unsigned DB_COUNT = 32,
    parameter int unsigned INST_ID  = 0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                we,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   rdata,
    output logic                dev_irq,
    output logic [DB_COUNT-1:0] doorbell
);

    localparam int unsigned DB_IDX = DB_COUNT - 1 - INST_ID;

    decode_t               dec;
    logic [N_DIR-1:0]      wr_en;
    dir_view_t [N_DIR-1:0] views;
    logic [N_DIR-1:0]      irq_dir;

    mbx_addr_decode u_dec (
        .addr  (addr),
        .we    (we),
        .dec   (dec),
        .wr_en (wr_en)
    );

    // Direction 0 goes to the device and owns the interrupt line
    for (genvar d = 0; d < N_DIR; d++) begin : g_dir
        mbx_dir_regs #(.HAS_IRQ(d == 0)) u_regs (
            .clk   (clk),
            .rst   (rst),
            .wr_en (wr_en[d]),
            .sel   (dec.sel),
            .wdata (wdata),
            .view  (views[d]),
            .irq   (irq_dir[d])
        );
    end

    mbx_read_mux u_rd (
        .dec   (dec),
        .views (views),
        .rdata (rdata)
    );

    assign dev_irq = irq_dir[0];

    for (genvar i = 0; i < DB_COUNT; i++) begin : g_db
        assign doorbell[i] = (i == DB_IDX) ? dev_irq : 1'b0;
    end

    logic unused_host_irq;
    assign unused_host_irq = irq_dir[N_DIR-1];

endmodule

// File: rtl/mbx_irq_csr_chk.sv
module mbx_irq_csr_chk
    import mbx_irq_pkg::*;
#(
    parameter int unsigned DB_COUNT = 32
) (
    input logic                clk,
    input logic                rst,
    input logic [ADDR_W-1:0]   addr,
    input logic                we,
    input logic [DATA_W-1:0]   rdata,
    input logic                dev_irq,
    input logic [DB_COUNT-1:0] doorbell
);

    localparam logic [ADDR_W-1:0] HOST_BIT    = ADDR_W'(1) << DIR_BIT;
    localparam logic [ADDR_W-1:0] A_GEN_DEV   = ADDR_W'(OFF_GEN);
    localparam logic [ADDR_W-1:0] A_CLR_DEV   = ADDR_W'(OFF_CLR);
    localparam logic [ADDR_W-1:0] A_GEN_HOST  = ADDR_W'(OFF_GEN) | HOST_BIT;
    localparam logic [ADDR_W-1:0] A_CLR_HOST  = ADDR_W'(OFF_CLR) | HOST_BIT;

    // R7
    clr_drops_irq_chk: assert property (@(posedge clk) disable iff (rst)
        (we && addr == A_CLR_DEV) |=> !dev_irq);

    // R5
    irq_rise_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(dev_irq) |-> $past(we && addr == A_GEN_DEV));

    // R7
    irq_fall_src_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(dev_irq) |-> $past((we && addr == A_CLR_DEV) || rst));

    // R9
    clr_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (addr == A_CLR_DEV || addr == A_CLR_HOST) |-> rdata == '0);

    // R11
    unaligned_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (addr[1:0] != 2'b00) |-> rdata == '0);

    // R12
    host_gen_no_irq_chk: assert property (@(posedge clk) disable iff (rst)
        (we && addr == A_GEN_HOST && !dev_irq) |=> !dev_irq);

    // R13
    doorbell_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(doorbell) && ($countones(doorbell) == 32'(dev_irq)));

endmodule

bind mbx_irq_csr mbx_irq_csr_chk #(.DB_COUNT(DB_COUNT)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .addr     (addr),
    .we       (we),
    .rdata    (rdata),
    .dev_irq  (dev_irq),
    .doorbell (doorbell)
);

// File: tb/mbx_irq_csr_tb.sv
module mbx_irq_csr_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  addr = '0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        dev_irq;
    logic [31:0] doorbell;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // Model state, from the requirements
    logic [31:0] m_gen [2];
    logic [31:0] m_mask [2];
    logic [31:0] m_armed [2];
    logic [31:0] m_stat [2];
    logic [31:0] m_mstat [2];
    logic        m_irq;

    always #4 clk = ~clk;   // 125 MHz

    mbx_irq_csr #(.DB_COUNT(32), .INST_ID(0)) u_dut (
        .clk      (clk),
        .rst      (rst),
        .addr     (addr),
        .we       (we),
        .wdata    (wdata),
        .rdata    (rdata),
        .dev_irq  (dev_irq),
        .doorbell (doorbell)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] mk_addr(input int dir, input logic [4:0] off);
        return {2'b00, dir[0], off};
    endfunction

    task automatic model_reset();
        for (int d = 0; d < 2; d++) begin
            m_gen[d] = '0; m_mask[d] = '0; m_armed[d] = '1;
            m_stat[d] = '0; m_mstat[d] = '1;
        end
        m_irq = 1'b0;
    endtask

    task automatic model_wr(input logic [7:0] a, input logic [31:0] v);
        int d;
        logic [31:0] f;
        if (a[7:6] != 2'b00 || a[1:0] != 2'b00) return;
        d = int'(a[5]);
        case (a[4:0])
            5'h00: begin
                m_gen[d] = v; m_stat[d] = v;
                f = v & m_mstat[d] & m_armed[d];
                if (f != 0) begin
                    m_armed[d] = m_armed[d] & ~f;
                    if (d == 0) m_irq = 1'b1;
                end
            end
            5'h04: begin m_mask[d] = v; m_mstat[d] = ~v; end
            5'h08: begin
                m_gen[d] = m_gen[d] & ~v; m_stat[d] = m_stat[d] & ~v;
                m_armed[d] = m_armed[d] | v;
                if (d == 0) m_irq = 1'b0;
            end
            default: ;
        endcase
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; we = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        model_reset();
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] v);
        @(negedge clk);
        addr = a; wdata = v; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
        model_wr(a, v);
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        addr = a; we = 1'b0;
        #1;
        v = rdata;
    endtask

    task automatic check_all(input string ctx);
        logic [31:0] v;
        for (int d = 0; d < 2; d++) begin
            rd(mk_addr(d, 5'h00), v); chk({ctx, " R3 gen"}, v, m_gen[d]);
            rd(mk_addr(d, 5'h0C), v); chk({ctx, " R3 status"}, v, m_stat[d]);
            rd(mk_addr(d, 5'h04), v); chk({ctx, " R8 mask"}, v, m_mask[d]);
            rd(mk_addr(d, 5'h10), v); chk({ctx, " R8 mask-status"}, v, m_mstat[d]);
            rd(mk_addr(d, 5'h08), v); chk({ctx, " R9 clear read"}, v, 32'h0);
        end
        chk({ctx, " R5 dev_irq"}, 32'(dev_irq), 32'(m_irq));
        chk({ctx, " R13 doorbell"}, doorbell, {m_irq, 31'b0});
    endtask

    initial begin
        logic [31:0] v;
        logic [7:0]  a;
        void'($urandom(32'd2024));
        model_reset();
        do_reset();

        // R2 reset state
        check_all("R2 reset");

        // R1 map: host status sits at 0x2C
        wr(8'h20, 32'h0000_00A5);
        rd(8'h2C, v); chk("R1 host status addr", v, 32'h0000_00A5);
        // R12 host generate leaves the device line alone
        chk("R12 host gen no irq", 32'(dev_irq), 32'h0);
        check_all("R12 host");

        // R5/R4: device generate fires, disarms bits
        wr(8'h00, 32'h0000_0003);
        chk("R5 irq set", 32'(dev_irq), 32'h1);
        // R7 clear of bit1 only drops the line, bit0 stays disarmed
        wr(8'h08, 32'h0000_0002);
        chk("R7 irq dropped", 32'(dev_irq), 32'h0);
        rd(8'h0C, v); chk("R6 status bit cleared", v, 32'h0000_0001);
        // R14 regenerate pending bit0: no new interrupt
        wr(8'h00, 32'h0000_0001);
        chk("R14 pending no refire", 32'(dev_irq), 32'h0);
        // R4 bit1 was re-armed and still fires
        wr(8'h00, 32'h0000_0002);
        chk("R4 rearmed bit fires", 32'(dev_irq), 32'h1);
        wr(8'h08, 32'h0000_0001);
        chk("R7 clear drops", 32'(dev_irq), 32'h0);
        // R14 after clearing bit0 it fires again
        wr(8'h00, 32'h0000_0001);
        chk("R14 refire after clear", 32'(dev_irq), 32'h1);
        check_all("R14 seq");

        // R8 masked source does not fire
        wr(8'h08, 32'hFFFF_FFFF);
        wr(8'h04, 32'h0000_0010);
        rd(8'h10, v); chk("R8 mask-status inverse", v, 32'hFFFF_FFEF);
        wr(8'h00, 32'h0000_0010);
        chk("R5 masked no irq", 32'(dev_irq), 32'h0);
        rd(8'h0C, v); chk("R3 status despite mask", v, 32'h0000_0010);

        // R10 read-only writes ignored
        wr(8'h0C, 32'hDEAD_BEEF);
        wr(8'h10, 32'h1234_5678);
        wr(8'h2C, 32'hFFFF_FFFF);
        wr(8'h30, 32'h0);
        check_all("R10 ro writes");

        // R11 unmapped reads and writes
        wr(8'h14, 32'hFFFF_FFFF);
        wr(8'h41, 32'hFFFF_FFFF);
        wr(8'hC0, 32'hFFFF_FFFF);
        rd(8'h02, v); chk("R11 unaligned read", v, 32'h0);
        rd(8'h84, v); chk("R11 high read", v, 32'h0);
        rd(8'h38, v); chk("R11 gap read", v, 32'h0);
        check_all("R11 unmapped writes");

        // Random traffic with fixed seed
        for (int i = 0; i < 400; i++) begin
            int d;
            logic [4:0] offs [5];
            offs = '{5'h00, 5'h04, 5'h08, 5'h0C, 5'h10};
            d = int'($urandom_range(0, 1));
            if ($urandom_range(0, 9) == 0)
                a = 8'($urandom);
            else
                a = mk_addr(d, offs[$urandom_range(0, 4)]);
            if ($urandom_range(0, 2) == 0) v = $urandom;
            else v = $urandom & 32'h0000_000F;
            wr(a, v);
            check_all("rand");
        end

        // R2 reset mid-run restores defaults
        wr(8'h00, 32'h1);
        do_reset();
        check_all("R2 re-reset");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule